// File: doc/BRIEF.md
# Bit-Masked Burst Address Counter

This block generates burst addresses for one port of a synchronous memory. It keeps an address counter and a mask register. Either one can be written from the same address input bus. A mask bit set to one lets the matching address bit take part in counting. A mask bit set to zero pins that bit at whatever value the last counter load gave it. When an increment is requested, the enabled bits behave as a single packed binary number. That number advances by one, and its carry jumps over the pinned positions.

A mask with one contiguous low field confines a burst to an aligned window. Pinning the low one or two bits gives a stride of two or four, on even or odd lines as chosen by the loaded start. Scattered masks walk arbitrary sub-lattices of the address space. When the packed field rolls over from all ones to zero, an active-low flag drops for a single cycle. Both registers are visible on output ports at all times. A synchronous clear puts the block back into its power-on state.

Top module: `masked_burst_counter`

## Requirements
- R1: While the asynchronous reset `rst_n` is low, and until the first clock edge after its synchronized release, `addr_out` is 0x0000, `mask_out` is all ones (0xFFFF at the default width) and `wrap_n` is 1.
- R2: `clr` is sampled at a rising edge and has priority over every other control. The next cycle shows `addr_out` = 0, `mask_out` = all ones and `wrap_n` = 1.
- R3: `mask_ld` without `clr` copies `addr_in` into the mask, which is visible on `mask_out` one cycle later. The counter keeps its value, and a `cnt_ld` or `step` in the same cycle is ignored.
- R4: `cnt_ld` without `clr` or `mask_ld` copies `addr_in` into the counter, visible on `addr_out` one cycle later. A `step` in the same cycle is ignored.
- R5: `step` alone gathers the counter bits whose mask bit is 1 into a packed number and adds one, modulo 2^k for k enabled bits. It then scatters the result back to the same positions. Bits with mask 0 keep their value. Example: mask 0x5555 loaded with 0x0007 then gives 0x0012, 0x0013, 0x0016.
- R6: With mask 0x00FF and start 0x00FD, three steps give 0x00FE, 0x00FF and 0x0000.
- R7: `wrap_n` is 0 for exactly the one cycle that follows a step whose packed field went from all ones to zero, and is 1 in every other cycle. Loads and clears never pull it low.
- R8: With an all-zero mask, a step leaves `addr_out` unchanged and never pulls `wrap_n` low.
- R9: Mask 0xFFFE gives a stride of 2 and mask 0xFFFC a stride of 4. The pinned low bits keep their loaded value, so an odd start stays on odd addresses.
- R10: Parameter `AW` sets the width (default 16). With `AW` = 15 a full mask counts 0x7FFE, 0x7FFF, 0x0000 and signals the wrap there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| clr | input | 1 | Synchronous master clear of counter, mask and flag |
| mask_ld | input | 1 | Load the mask register from `addr_in` |
| cnt_ld | input | 1 | Load the counter from `addr_in` |
| step | input | 1 | Advance the unmasked field by one |
| addr_in | input | AW | Value for mask or counter loads |
| addr_out | output | AW | Current counter value (burst address and readback) |
| mask_out | output | AW | Current mask register value (readback) |
| wrap_n | output | 1 | Active-low one-cycle wrap flag |

## Verification
Every result of this block arrives one rising edge after the control that caused it. Loads, clears and steps all land together with their `wrap_n` value, and none passes through a second register stage. The bench drives each control on a falling edge, lets exactly one rising edge pass, and reads the outputs on the following falling edge. A wrap is therefore seen in the same sample as the zero address. The return of `wrap_n` to high is checked one sample later, with the controls idle. The only multi-cycle latency is the two-edge release of the reset synchronizer, and the bench waits it out before its first functional check.

// File: rtl/bmc_pkg.sv
package bmc_pkg;
  // Decoded control for one cycle, highest priority wins.
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_CLEAR = 3'd1,
    OP_MASK  = 3'd2,
    OP_LOAD  = 3'd3,
    OP_STEP  = 3'd4
  } bmc_op_e;
endpackage

// File: rtl/bmc_rst_sync.sv
module bmc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/bmc_ctl_dec.sv
module bmc_ctl_dec
  import bmc_pkg::*;
(
  input  logic    clr,
  input  logic    mask_ld,
  input  logic    cnt_ld,
  input  logic    step,
  output bmc_op_e op
);
  always_comb begin
    if (clr)          op = OP_CLEAR;
    else if (mask_ld) op = OP_MASK;
    else if (cnt_ld)  op = OP_LOAD;
    else if (step)    op = OP_STEP;
    else              op = OP_HOLD;
  end
endmodule

// File: rtl/bmc_masked_inc.sv
module bmc_masked_inc #(
  parameter int AW = 16
) (
  input  logic [AW-1:0] cur,
  input  logic [AW-1:0] mask,
  output logic [AW-1:0] nxt,
  output logic          wrap
);
  // Ripple carry that passes straight through pinned positions.
  logic [AW:0] carry;
  assign carry[0] = 1'b1;

  for (genvar gi = 0; gi < AW; gi++) begin : g_bit
    assign nxt[gi]      = mask[gi] ? (cur[gi] ^ carry[gi]) : cur[gi];
    assign carry[gi+1]  = mask[gi] ? (cur[gi] & carry[gi]) : carry[gi];
  end

  // Carry out of the packed field means all ones rolled to zero.
  assign wrap = carry[AW] & (|mask);
endmodule

// File: rtl/masked_burst_counter.sv
module masked_burst_counter
  import bmc_pkg::*;
#(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          mask_ld,
  input  logic          cnt_ld,
  input  logic          step,
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out,
  output logic [AW-1:0] mask_out,
  output logic          wrap_n
);
  localparam logic [AW-1:0] CNT_INIT  = '0;
  localparam logic [AW-1:0] MASK_INIT = '1;

  logic          rst_sync_n;
  bmc_op_e       op;
  logic [AW-1:0] cnt_q, cnt_d, mask_q, mask_d, inc_val;
  logic          inc_wrap, wrap_n_q, wrap_n_d;
  logic          cnt_en, mask_en;

  bmc_rst_sync #(.STAGES(2)) u_rst_sync (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  bmc_ctl_dec u_ctl_dec (
    .clr     (clr),
    .mask_ld (mask_ld),
    .cnt_ld  (cnt_ld),
    .step    (step),
    .op      (op)
  );

  bmc_masked_inc #(.AW(AW)) u_inc (
    .cur  (cnt_q),
    .mask (mask_q),
    .nxt  (inc_val),
    .wrap (inc_wrap)
  );

  // Next-state and clock enables.
  always_comb begin
    cnt_d    = cnt_q;
    mask_d   = mask_q;
    cnt_en   = 1'b0;
    mask_en  = 1'b0;
    wrap_n_d = 1'b1;
    case (op)
      OP_CLEAR: begin
        cnt_d   = CNT_INIT;
        mask_d  = MASK_INIT;
        cnt_en  = 1'b1;
        mask_en = 1'b1;
      end
      OP_MASK: begin
        mask_d  = addr_in;
        mask_en = 1'b1;
      end
      OP_LOAD: begin
        cnt_d  = addr_in;
        cnt_en = 1'b1;
      end
      OP_STEP: begin
        cnt_d    = inc_val;
        cnt_en   = 1'b1;
        wrap_n_d = ~inc_wrap;
      end
      default: ;
    endcase
  end

  // Registers.
  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      cnt_q    <= CNT_INIT;
      mask_q   <= MASK_INIT;
      wrap_n_q <= 1'b1;
    end else begin
      if (cnt_en)  cnt_q  <= cnt_d;
      if (mask_en) mask_q <= mask_d;
      wrap_n_q <= wrap_n_d;
    end
  end

  assign addr_out = cnt_q;
  assign mask_out = mask_q;
  assign wrap_n   = wrap_n_q;

  // R2
  clear_state_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    clr |=> (addr_out == CNT_INIT) && (mask_out == MASK_INIT) && wrap_n);

  // R3
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (mask_ld && !clr) |=> (mask_out == $past(addr_in)) && (addr_out == $past(addr_out)) && wrap_n);

  // R4
  cnt_load_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (cnt_ld && !mask_ld && !clr) |=> (addr_out == $past(addr_in)) && wrap_n);

  // R5
  pinned_bits_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step && !cnt_ld && !mask_ld && !clr) |=>
      ((addr_out & ~mask_out) == ($past(addr_out) & ~mask_out)));

  // R7
  wrap_pulse_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !wrap_n |=> wrap_n);

  // R7
  wrap_cause_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    $fell(wrap_n) |-> ($past(step) && !$past(cnt_ld) && !$past(mask_ld) && !$past(clr)
                       && (addr_out & mask_out) == '0));

  // R8
  zero_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (step && !cnt_ld && !mask_ld && !clr && mask_out == '0) |=> $stable(addr_out) && wrap_n);
endmodule

// File: tb/masked_burst_counter_bench.sv
module masked_burst_counter_bench;
  logic        clk = 1'b0;
  logic        rst_n, clr, mask_ld, cnt_ld, step;
  logic [15:0] addr_in, addr_out, mask_out;
  logic        wrap_n;
  logic [14:0] n_addr, n_mask;
  logic        n_wrap_n;
  int          n_run = 0;
  int          n_fail = 0;

  always #5 clk = ~clk;

  masked_burst_counter #(.AW(16)) u_masked_burst_counter (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mask_ld(mask_ld), .cnt_ld(cnt_ld),
    .step(step), .addr_in(addr_in), .addr_out(addr_out), .mask_out(mask_out),
    .wrap_n(wrap_n)
  );

  masked_burst_counter #(.AW(15)) u_masked_burst_counter_w15 (
    .clk(clk), .rst_n(rst_n), .clr(clr), .mask_ld(mask_ld), .cnt_ld(cnt_ld),
    .step(step), .addr_in(addr_in[14:0]), .addr_out(n_addr), .mask_out(n_mask),
    .wrap_n(n_wrap_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual 0x%04h expected 0x%04h", req, act, exp);
    end
  endtask

  // Drive on a falling edge, return on the next falling edge with controls idle.
  task automatic cyc(input logic c, input logic m, input logic l, input logic s,
                     input logic [15:0] a);
    clr = c; mask_ld = m; cnt_ld = l; step = s; addr_in = a;
    @(negedge clk);
    clr = 0; mask_ld = 0; cnt_ld = 0; step = 0; addr_in = 16'h0;
  endtask

  // Packed-field model: gather, add one, scatter.
  function automatic logic [15:0] model_step(input logic [15:0] cur, input logic [15:0] m,
                                             output logic wr);
    int unsigned field = 0;
    int          k = 0;
    logic [15:0] res = cur;
    for (int i = 0; i < 16; i++)
      if (m[i]) begin field |= int'(cur[i]) << k; k++; end
    field = (field + 1) & ((32'd1 << k) - 1);
    wr = (k > 0) && (field == 0);
    k = 0;
    for (int i = 0; i < 16; i++)
      if (m[i]) begin res[i] = field[k]; k++; end
    return res;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [15:0] exp_a;
    logic        wr;
    logic [15:0] masks [8] = '{16'hFFFF, 16'h00FF, 16'h5555, 16'hFFFE,
                              16'hFFFC, 16'h0000, 16'hA0F1, 16'h8001};
    logic [15:0] starts [4] = '{16'h0000, 16'h0007, 16'hFFFD, 16'h1234};

    rst_n = 0; clr = 0; mask_ld = 0; cnt_ld = 0; step = 0; addr_in = 0;
    repeat (3) @(negedge clk);
    chk("R1 addr in reset", addr_out, 16'h0000);
    chk("R1 mask in reset", mask_out, 16'hFFFF);
    chk("R1 wrap_n in reset", {15'd0, wrap_n}, 16'h0001);
    rst_n = 1;
    repeat (3) @(negedge clk);
    chk("R1 addr after release", addr_out, 16'h0000);

    // R6 window example and R7 pulse
    cyc(0, 1, 0, 0, 16'h00FF);
    chk("R3 mask readback", mask_out, 16'h00FF);
    cyc(0, 0, 1, 0, 16'h00FD);
    chk("R4 load", addr_out, 16'h00FD);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R6 step1", addr_out, 16'h00FE);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R6 step2", addr_out, 16'h00FF);
    chk("R7 no wrap before rollover", {15'd0, wrap_n}, 16'h0001);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R6 step3", addr_out, 16'h0000);
    chk("R7 wrap low", {15'd0, wrap_n}, 16'h0000);
    @(negedge clk);
    chk("R7 wrap back high", {15'd0, wrap_n}, 16'h0001);

    // R5 scattered example
    cyc(0, 1, 0, 0, 16'h5555);
    cyc(0, 0, 1, 0, 16'h0007);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R5 scatter 1", addr_out, 16'h0012);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R5 scatter 2", addr_out, 16'h0013);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R5 scatter 3", addr_out, 16'h0016);

    // R3 priority over load and step
    cyc(0, 1, 1, 1, 16'h0F0F);
    chk("R3 mask wins", mask_out, 16'h0F0F);
    chk("R3 counter untouched", addr_out, 16'h0016);

    // R4 step ignored with load; R7 load never lowers flag
    cyc(0, 1, 0, 0, 16'hFFFF);
    cyc(0, 0, 1, 1, 16'hFFFF);
    chk("R4 step ignored", addr_out, 16'hFFFF);
    cyc(0, 0, 1, 1, 16'h0000);
    chk("R4 load zero", addr_out, 16'h0000);
    chk("R7 load keeps flag high", {15'd0, wrap_n}, 16'h0001);

    // R2 clear beats everything
    cyc(0, 1, 0, 0, 16'h0033);
    cyc(0, 0, 1, 0, 16'h0021);
    cyc(1, 1, 1, 1, 16'h1111);
    chk("R2 clear addr", addr_out, 16'h0000);
    chk("R2 clear mask", mask_out, 16'hFFFF);
    chk("R2 clear flag", {15'd0, wrap_n}, 16'h0001);

    // R9 strides
    cyc(0, 1, 0, 0, 16'hFFFE);
    cyc(0, 0, 1, 0, 16'h0003);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R9 stride2 a", addr_out, 16'h0005);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R9 stride2 b", addr_out, 16'h0007);
    cyc(0, 1, 0, 0, 16'hFFFC);
    cyc(0, 0, 1, 0, 16'h0002);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R9 stride4 a", addr_out, 16'h0006);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R9 stride4 b", addr_out, 16'h000A);

    // R8 zero mask
    cyc(0, 1, 0, 0, 16'h0000);
    cyc(0, 0, 1, 0, 16'hBEEF);
    for (int i = 0; i < 4; i++) begin
      cyc(0, 0, 0, 1, 16'h0);
      chk("R8 addr frozen", addr_out, 16'hBEEF);
      chk("R8 no flag", {15'd0, wrap_n}, 16'h0001);
    end

    // R5/R7 sweep against the packed-field model
    for (int mi = 0; mi < 8; mi++) begin
      for (int si = 0; si < 4; si++) begin
        cyc(0, 1, 0, 0, masks[mi]);
        cyc(0, 0, 1, 0, starts[si]);
        exp_a = starts[si];
        for (int n = 0; n < 40; n++) begin
          exp_a = model_step(exp_a, masks[mi], wr);
          cyc(0, 0, 0, 1, 16'h0);
          chk("R5 sweep addr", addr_out, exp_a);
          chk("R7 sweep flag", {15'd0, wrap_n}, {15'd0, ~wr});
        end
      end
    end

    // R10 narrow variant
    cyc(1, 0, 0, 0, 16'h0);
    chk("R10 narrow mask reset", {1'b0, n_mask}, 16'h7FFF);
    cyc(0, 0, 1, 0, 16'h7FFE);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R10 narrow top", {1'b0, n_addr}, 16'h7FFF);
    cyc(0, 0, 0, 1, 16'h0);
    chk("R10 narrow wrap addr", {1'b0, n_addr}, 16'h0000);
    chk("R10 narrow wrap flag", {15'd0, n_wrap_n}, 16'h0000);

    // R1 asynchronous assertion mid-run
    cyc(0, 0, 1, 0, 16'h4321);
    rst_n = 0;
    #1;
    chk("R1 async addr", addr_out, 16'h0000);
    chk("R1 async mask", mask_out, 16'hFFFF);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule